// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This block is a cycle-level model of the command logic inside a byte-wide parallel flash memory. The host talks to it only through bus cycles. A write cycle is a clock edge at which chip select and write strobe are both low. A read cycle is a clock edge at which chip select and output strobe are low and the write strobe is high. Write cycles pass through an unlock-sequence state machine. That machine decodes them into the following commands:

- program
- unlock-bypass entry, program and exit
- sector erase and chip erase
- erase suspend and erase resume
- return to read mode

A program or erase runs on internal counters and needs nothing further from the host. While it runs, a read returns a status byte in place of array contents. In that byte, bit 7 is the inverse of the byte being written, and bit 6 flips on every status read. The host detects completion by polling these bits.

The array is a parameterised memory. Its default is 2048 bytes in eight equal sectors, and it starts fully erased (0xFF). The sector number is the top `SEC_W` address bits. Unlock addresses are matched on address bits 10:0, so `ADDR_W` must be at least 11. `ERASE_WAIT` must not exceed the array depth.

The controller states are listed below.

| State | Meaning and exits |
|---|---|
| `S_IDLE` | Read mode, with `bypass_q` and `susp_q` flags. It goes to `S_UL1` on 0xAA@0x555. In bypass it goes to `S_PGM` on 0xA0. In suspend it returns to `S_ERASE` on 0x30. |
| `S_UL1` | Moves to `S_UL2` on 0x55@0x2AA, otherwise back to `S_IDLE`. |
| `S_UL2` | On 0xA0@0x555 goes to `S_PGM`. On 0x80@0x555 goes to `S_EUL0`. On 0x20@0x555 sets bypass and goes to `S_IDLE`. Anything else returns to `S_IDLE`. |
| `S_PGM` | The next write latches the address and data and goes to `S_PROG`. It goes to `S_IDLE` instead if the target is refused. |
| `S_EUL0` | Moves to `S_EUL1` on 0xAA@0x555, otherwise back to `S_IDLE`. |
| `S_EUL1` | Moves to `S_EUL2` on 0x55@0x2AA, otherwise back to `S_IDLE`. |
| `S_EUL2` | On 0x10@0x555 goes to `S_ERASE` for the whole chip. On 0x30 goes to `S_SEL` for the addressed sector. |
| `S_SEL` | Collects further 0x30 sector writes, then goes to `S_ERASE` after `SEL_WIN` quiet cycles. |
| `S_PROG` | Runs for `PROG_CYC` cycles, writes old AND data, then returns to `S_IDLE`. |
| `S_ERASE` | Runs three phases: PRE sweep (write 0x00), WAIT, FILL sweep (write 0xFF), then returns to `S_IDLE`. On 0xB0 it suspends and goes to `S_IDLE` with `susp_q` set. |

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the block is in read mode with bypass and suspend cleared. Every byte of the array reads 0xFF. Read data appear one clock after the read cycle. `dout` is 0x00 in any cycle that follows a non-read cycle.
- R2: The program sequence is 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then the address and data. The program takes `PROG_CYC` cycles and stores old AND data. A read while it runs returns bit 7 = inverse of data bit 7, bit 6 flipping on each read, and bits 5:0 = 0. Afterwards, reads return the array data.
- R3: 0xAA@0x555, 0x55@0x2AA, 0x20@0x555 enters bypass. In bypass, 0xA0 at any address followed by an address/data write programs a byte. 0xF0 leaves bypass. After exit, the two-cycle form writes nothing.
- R4: A cycle with the wrong data or address inside an unlock sequence returns the block to read mode. This includes 0xF0. A following 0xA0 plus data write changes nothing.
- R5: The sector erase sequence is 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address of the sector. The erase starts `SEL_WIN` cycles after the last 0x30. It sets every byte of the chosen sectors to 0x00, then to 0xFF. Bytes in other sectors are unchanged.
- R6: Each extra 0x30 write inside the window adds its sector. A final cycle of 0x10@0x555 instead erases every unprotected sector.
- R7: 0xB0 during an erase suspends it. While suspended, reads return array contents. A program to a sector outside the erase set is performed, and one inside it is ignored. 0x30 resumes the erase, which then completes.
- R8: With `prot[s]` high, a program aimed at sector s is refused and never reports busy. Every erase leaves sector s unchanged.
- R9: While `lowvcc` is high, every bus write cycle is ignored.
- R10: During an erase, a status read returns bit 7 = 0, with bit 6 flipping on each read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data or command code |
| lowvcc | input | 1 | Low-supply flag, blocks writes |
| prot | input | SECTORS | Per-sector protection |
| dout | output | DATA_W | Read data or status, one cycle after the read |

## Verification
The checker watches several rules on every cycle:

- a protected program target never reaches `S_PROG`
- the bypass and suspend flags never move while `lowvcc` is high
- bypass can only be entered from `S_UL2`, and suspend only from `S_ERASE`
- back-to-back busy reads flip bit 6
- program status carries the inverted data bit
- `dout` is quiet after non-read cycles

Only the directed scenarios can show that the array holds the right values afterwards: AND-merging on program, the 0x00 preprogram pass (seen through a suspend), sectors outside the erase set left intact, erases that skip protected sectors, and erases that finish after a resume.

// File: rtl/flash_pkg.sv
`timescale 1ns/1ps
package flash_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_UL1, S_UL2, S_PGM, S_EUL0, S_EUL1, S_EUL2,
        S_PROG, S_SEL, S_ERASE
    } fsm_e;

    typedef enum logic [1:0] {PH_PRE, PH_WAIT, PH_FILL} phase_e;

    localparam logic [7:0]  CMD_KEY1   = 8'hAA;
    localparam logic [7:0]  CMD_KEY2   = 8'h55;
    localparam logic [7:0]  CMD_PROG   = 8'hA0;
    localparam logic [7:0]  CMD_ESETUP = 8'h80;
    localparam logic [7:0]  CMD_SECT   = 8'h30;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_BYPASS = 8'h20;
    localparam logic [7:0]  CMD_SUSP   = 8'hB0;
    localparam logic [7:0]  CMD_RESUME = 8'h30;
    localparam logic [7:0]  CMD_RESET  = 8'hF0;
    localparam logic [10:0] KEY_ADDR1  = 11'h555;
    localparam logic [10:0] KEY_ADDR2  = 11'h2AA;
endpackage

// File: rtl/flash_array.sv
`timescale 1ns/1ps
module flash_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              and_mode,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array leaves the factory erased.
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '1;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= and_mode ? (mem[waddr] & wdata) : wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/flash_status.sv
`timescale 1ns/1ps
module flash_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              busy,
    input  logic              prog_mode,
    input  logic              pdata_msb,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dout
);
    logic              rd_q, sel_q, tog_q;
    logic [DATA_W-1:0] stat_q, stat_d;

    always_comb begin
        stat_d           = '0;
        stat_d[DATA_W-1] = prog_mode ? ~pdata_msb : 1'b0;
        stat_d[DATA_W-2] = tog_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            sel_q  <= 1'b0;
            tog_q  <= 1'b0;
            stat_q <= '0;
        end else begin
            rd_q  <= rd;
            sel_q <= rd & busy;
            if (rd && busy) begin
                stat_q <= stat_d;
                tog_q  <= ~tog_q;
            end
        end
    end

    assign dout = !rd_q ? '0 : (sel_q ? stat_q : arr_data);
endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
    import flash_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int SECTORS    = 8,
    parameter int PROG_CYC   = 8,
    parameter int ERASE_WAIT = 32,
    parameter int SEL_WIN    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_n,
    input  logic               we_n,
    input  logic               oe_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  din,
    input  logic               lowvcc,
    input  logic [SECTORS-1:0] prot,
    output logic [DATA_W-1:0]  dout
);
    localparam int SEC_W   = $clog2(SECTORS);
    localparam int CNT_MAX = (PROG_CYC > SEL_WIN) ? PROG_CYC : SEL_WIN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [ADDR_W-1:0] LAST = '1;

    fsm_e               state_q, state_d;
    phase_e             ph_q, ph_d;
    logic               bypass_q, bypass_d, susp_q, susp_d;
    logic [SECTORS-1:0] emask_q, emask_d, sec_oh;
    logic [ADDR_W-1:0]  paddr_q, paddr_d, ptr_q, ptr_d;
    logic [DATA_W-1:0]  pdata_q, pdata_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               wr, rd, busy, at_k1, at_k2;
    logic [SEC_W-1:0]   sec, ptr_sec;
    logic               a_we, a_and;
    logic [ADDR_W-1:0]  a_waddr;
    logic [DATA_W-1:0]  a_wdata, a_rdata;

    assign wr      = ~ce_n & ~we_n & ~lowvcc;
    assign rd      = ~ce_n & ~oe_n & we_n;
    assign at_k1   = addr[10:0] == KEY_ADDR1;
    assign at_k2   = addr[10:0] == KEY_ADDR2;
    assign sec     = addr[ADDR_W-1 -: SEC_W];
    assign ptr_sec = ptr_q[ADDR_W-1 -: SEC_W];
    assign sec_oh  = {{(SECTORS-1){1'b0}}, 1'b1} << sec;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            ph_q     <= PH_PRE;
            bypass_q <= 1'b0;
            susp_q   <= 1'b0;
            emask_q  <= '0;
            paddr_q  <= '0;
            pdata_q  <= '0;
            ptr_q    <= '0;
            cnt_q    <= '0;
        end else begin
            state_q  <= state_d;
            ph_q     <= ph_d;
            bypass_q <= bypass_d;
            susp_q   <= susp_d;
            emask_q  <= emask_d;
            paddr_q  <= paddr_d;
            pdata_q  <= pdata_d;
            ptr_q    <= ptr_d;
            cnt_q    <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        ph_d     = ph_q;
        bypass_d = bypass_q;
        susp_d   = susp_q;
        emask_d  = emask_q;
        paddr_d  = paddr_q;
        pdata_d  = pdata_q;
        ptr_d    = ptr_q;
        cnt_d    = cnt_q;
        unique case (state_q)
            S_IDLE: if (wr) begin
                if (susp_q && din == CMD_RESUME) begin
                    susp_d  = 1'b0;
                    state_d = S_ERASE;
                end else if (bypass_q && din == CMD_PROG) begin
                    state_d = S_PGM;
                end else if (bypass_q && din == CMD_RESET) begin
                    bypass_d = 1'b0;
                end else if (!bypass_q && din == CMD_KEY1 && at_k1) begin
                    state_d = S_UL1;
                end
            end
            S_UL1:  if (wr) state_d = (din == CMD_KEY2 && at_k2) ? S_UL2 : S_IDLE;
            S_UL2:  if (wr) begin
                state_d = S_IDLE;
                if (at_k1 && din == CMD_PROG) state_d = S_PGM;
                else if (at_k1 && !susp_q && din == CMD_ESETUP) state_d = S_EUL0;
                else if (at_k1 && !susp_q && din == CMD_BYPASS) bypass_d = 1'b1;
            end
            S_PGM:  if (wr) begin
                state_d = S_IDLE;
                if (!prot[sec] && !(susp_q && emask_q[sec])) begin
                    paddr_d = addr;
                    pdata_d = din;
                    cnt_d   = '0;
                    state_d = S_PROG;
                end
            end
            S_EUL0: if (wr) state_d = (din == CMD_KEY1 && at_k1) ? S_EUL1 : S_IDLE;
            S_EUL1: if (wr) state_d = (din == CMD_KEY2 && at_k2) ? S_EUL2 : S_IDLE;
            S_EUL2: if (wr) begin
                state_d = S_IDLE;
                if (din == CMD_CHIP && at_k1) begin
                    emask_d = ~prot;
                    ph_d    = PH_PRE;
                    ptr_d   = '0;
                    if (|(~prot)) state_d = S_ERASE;
                end else if (din == CMD_SECT) begin
                    emask_d = sec_oh & ~prot;
                    cnt_d   = '0;
                    state_d = S_SEL;
                end
            end
            S_SEL: begin
                if (wr && din == CMD_SECT) begin
                    emask_d = emask_q | (sec_oh & ~prot);
                    cnt_d   = '0;
                end else if (cnt_q == CNT_W'(SEL_WIN - 1)) begin
                    ph_d    = PH_PRE;
                    ptr_d   = '0;
                    state_d = (|emask_q) ? S_ERASE : S_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_PROG: begin
                if (cnt_q == CNT_W'(PROG_CYC - 1)) state_d = S_IDLE;
                else cnt_d = cnt_q + 1'b1;
            end
            S_ERASE: begin
                if (wr && din == CMD_SUSP) begin
                    susp_d  = 1'b1;
                    state_d = S_IDLE;
                end else begin
                    unique case (ph_q)
                        PH_PRE: begin
                            ptr_d = ptr_q + 1'b1;
                            if (ptr_q == LAST) ph_d = PH_WAIT;
                        end
                        PH_WAIT: begin
                            if (ptr_q == ADDR_W'(ERASE_WAIT - 1)) begin
                                ptr_d = '0;
                                ph_d  = PH_FILL;
                            end else begin
                                ptr_d = ptr_q + 1'b1;
                            end
                        end
                        PH_FILL: begin
                            ptr_d = ptr_q + 1'b1;
                            if (ptr_q == LAST) begin
                                emask_d = '0;
                                state_d = S_IDLE;
                            end
                        end
                        default: ph_d = PH_PRE;
                    endcase
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        a_we    = 1'b0;
        a_and   = 1'b0;
        a_waddr = ptr_q;
        a_wdata = '0;
        busy    = state_q == S_PROG || state_q == S_SEL || state_q == S_ERASE;
        if (state_q == S_PROG && cnt_q == CNT_W'(PROG_CYC - 1)) begin
            a_we    = 1'b1;
            a_and   = 1'b1;
            a_waddr = paddr_q;
            a_wdata = pdata_q;
        end else if (state_q == S_ERASE && ph_q != PH_WAIT && emask_q[ptr_sec]) begin
            a_we    = 1'b1;
            a_wdata = (ph_q == PH_FILL) ? '1 : '0;
        end
    end

    flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .we(a_we), .and_mode(a_and), .waddr(a_waddr),
        .wdata(a_wdata), .raddr(addr), .rdata(a_rdata)
    );

    flash_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .rd(rd), .busy(busy),
        .prog_mode(state_q == S_PROG), .pdata_msb(pdata_q[DATA_W-1]),
        .arr_data(a_rdata), .dout(dout)
    );
endmodule

// File: rtl/flash_cmd_chk.sv
`timescale 1ns/1ps
module flash_cmd_chk
    import flash_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SECTORS = 8,
    parameter int SEC_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd,
    input logic               wr,
    input logic               lowvcc,
    input logic [SECTORS-1:0] prot,
    input logic [SEC_W-1:0]   sec,
    input fsm_e               state_q,
    input logic               bypass_q,
    input logic               susp_q,
    input logic               busy,
    input logic               pdata_msb,
    input logic [DATA_W-1:0]  dout
);
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> dout == '0);

    p_prog_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && busy && state_q == S_PROG) |=> dout[DATA_W-1] == ~$past(pdata_msb));

    p_bypass_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass_q) |-> $past(state_q) == S_UL2);

    p_susp_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_q) |-> $past(state_q) == S_ERASE);

    p_prot_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PGM && wr && prot[sec]) |=> state_q != S_PROG);

    p_lowvcc_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lowvcc |=> $stable(bypass_q) && $stable(susp_q));

    p_lowvcc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lowvcc && state_q == S_IDLE) |=> state_q == S_IDLE);

    p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && busy && $past(rd && busy)) |=> dout[DATA_W-2] != $past(dout[DATA_W-2]));
endmodule

bind flash_cmd_fsm flash_cmd_chk #(.DATA_W(DATA_W), .SECTORS(SECTORS), .SEC_W(SEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .lowvcc(lowvcc), .prot(prot),
    .sec(sec), .state_q(state_q), .bypass_q(bypass_q), .susp_q(susp_q),
    .busy(busy), .pdata_msb(pdata_q[DATA_W-1]), .dout(dout)
);

// File: tb/flash_cmd_fsm_test.sv
`timescale 1ns/1ps
module flash_cmd_fsm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lowvcc = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0, prot = '0, dout;
    int          checks = 0, errors = 0;

    flash_cmd_fsm uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .lowvcc(lowvcc), .prot(prot), .dout(dout)
    );

    always #4 clk = ~clk;

    localparam int LONG = 4300;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; d = dout;
    endtask

    task automatic prog4(input logic [10:0] a, input logic [7:0] d);
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55);
        bus_wr(11'h555, 8'hA0); bus_wr(a, d);
    endtask

    task automatic erase_setup();
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'h80);
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        idle(1);
        chk("R1 quiet output", dout, 8'h00);
        bus_rd(11'h000, v); chk("R1 erased byte", v, 8'hFF);
        bus_rd(11'h7FF, v); chk("R1 erased last byte", v, 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] s1, s2, v;
        prog4(11'h040, 8'h5A);
        bus_rd(11'h040, s1); bus_rd(11'h040, s2);
        chk("R2 status bit7 inverted", {7'd0, s1[7]}, 8'h01);
        chk("R2 status low bits", {2'b00, s1[5:0]}, 8'h00);
        chk("R2 status bit6 toggles", {7'd0, s1[6] ^ s2[6]}, 8'h01);
        idle(12);
        bus_rd(11'h040, v); chk("R2 programmed value", v, 8'h5A);
        prog4(11'h040, 8'h0F); idle(12);
        bus_rd(11'h040, v); chk("R2 AND merge", v, 8'h0A);
    endtask

    task automatic t_bad_seq();
        logic [7:0] v;
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h12);
        bus_wr(11'h555, 8'hA0); bus_wr(11'h041, 8'h33);
        bus_rd(11'h041, v); chk("R4 wrong key ignored", v, 8'hFF);
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'hF0);
        bus_wr(11'h555, 8'hA0); bus_wr(11'h042, 8'h33); idle(12);
        bus_rd(11'h042, v); chk("R4 reset in sequence", v, 8'hFF);
    endtask

    task automatic t_bypass();
        logic [7:0] v;
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'h20);
        bus_wr(11'h000, 8'hA0); bus_wr(11'h300, 8'hC3); idle(12);
        bus_rd(11'h300, v); chk("R3 bypass program", v, 8'hC3);
        bus_wr(11'h000, 8'hF0);
        bus_wr(11'h000, 8'hA0); bus_wr(11'h301, 8'h00); idle(12);
        bus_rd(11'h301, v); chk("R3 after bypass exit", v, 8'hFF);
    endtask

    task automatic t_lowvcc();
        logic [7:0] v;
        lowvcc = 1'b1;
        prog4(11'h302, 8'h00);
        bus_rd(11'h302, v); chk("R9 no busy under lowvcc", v, 8'hFF);
        idle(12);
        bus_rd(11'h302, v); chk("R9 write inhibited", v, 8'hFF);
        lowvcc = 1'b0;
    endtask

    task automatic t_protect();
        logic [7:0] v;
        prog4(11'h520, 8'h44); idle(12);
        prot = 8'h20;
        prog4(11'h520, 8'h00);
        bus_rd(11'h520, v); chk("R8 refused program not busy", v, 8'h44);
        idle(12);
        bus_rd(11'h520, v); chk("R8 protected byte kept", v, 8'h44);
    endtask

    task automatic t_sector_erase();
        logic [7:0] s1, s2, v;
        prog4(11'h100, 8'h21); idle(12);
        erase_setup();
        bus_wr(11'h300, 8'h30); bus_wr(11'h100, 8'h30);
        bus_rd(11'h000, s1); bus_rd(11'h000, s2);
        chk("R10 erase status bit7", {7'd0, s1[7]}, 8'h00);
        chk("R10 erase bit6 toggles", {7'd0, s1[6] ^ s2[6]}, 8'h01);
        idle(LONG);
        bus_rd(11'h300, v); chk("R5 sector erased", v, 8'hFF);
        bus_rd(11'h100, v); chk("R6 added sector erased", v, 8'hFF);
        bus_rd(11'h040, v); chk("R5 other sector kept", v, 8'h0A);
    endtask

    task automatic t_suspend();
        logic [7:0] v;
        prog4(11'h210, 8'h77); idle(12);
        prog4(11'h620, 8'h66); idle(12);
        erase_setup();
        bus_wr(11'h200, 8'h30);
        idle(1000);
        bus_wr(11'h000, 8'hB0); idle(2);
        bus_rd(11'h210, v); chk("R5 preprogram to 00", v, 8'h00);
        bus_rd(11'h620, v); chk("R7 read while suspended", v, 8'h66);
        prog4(11'h630, 8'h12); idle(12);
        bus_rd(11'h630, v); chk("R7 program while suspended", v, 8'h12);
        prog4(11'h220, 8'h00);
        bus_rd(11'h220, v); chk("R7 erasing sector refused", v, 8'h00);
        bus_wr(11'h000, 8'h30); idle(LONG);
        bus_rd(11'h210, v); chk("R7 erase completes after resume", v, 8'hFF);
        bus_rd(11'h630, v); chk("R7 suspended program kept", v, 8'h12);
        bus_rd(11'h620, v); chk("R7 outside sector kept", v, 8'h66);
    endtask

    task automatic t_chip_erase();
        logic [7:0] v;
        erase_setup();
        bus_wr(11'h555, 8'h10); idle(LONG);
        bus_rd(11'h630, v); chk("R6 chip erase", v, 8'hFF);
        bus_rd(11'h040, v); chk("R6 chip erase sector0", v, 8'hFF);
        bus_rd(11'h520, v); chk("R8 protected survives chip erase", v, 8'h44);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_bad_seq();
        t_bypass();
        t_lowvcc();
        t_protect();
        t_sector_erase();
        t_suspend();
        t_chip_erase();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule